// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device side of a three-wire serial memory. The host drives chip select, a serial clock and a serial data input. The block decodes each frame, answers reads on a serial output that it can release to high impedance, and carries out programming operations on an internal register array. A strap input selects either 16-bit words or 8-bit words. The address width follows that choice.

Programming is self-timed. After a write or erase has been accepted, an internal counter keeps the device busy for `PROG_CYC` system clocks and updates the array when the count ends. A host can poll the device by taking chip select low and then high again: the serial output then reports busy or ready. All three serial inputs are synchronized into the system clock domain, and every serial-clock edge is detected there. Array depth and programming time are parameters, so a simulation can use small values.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset, programming is disabled and `dout_oe` is low. A WRITE frame sent before any enable starts no programming cycle: after chip select goes low and high again, `dout_oe` stays low.
- R2: A frame begins at the first serial-clock rising edge with `cs` high and `din` = 1 (the start bit). Two opcode bits follow, then the address. Opcode 10 is READ, 01 is WRITE and 11 is ERASE. For opcode 00 the two most significant address bits select the command: 11 enable, 00 disable, 10 erase-all, 01 write-all. The remaining address bits are ignored.
- R3: With `org16` = 1, words are 16 bits wide and the address has ADDR_W bits. With `org16` = 0, words are 8 bits wide and the address has ADDR_W+1 bits. Byte address 2k holds the low byte of 16-bit word k, and byte address 2k+1 holds its high byte.
- R4: READ works whether programming is enabled or not. On the rising edge that carries the last address bit, `dout` drives a 0. Each following rising edge shifts out one data bit, MSB first.
- R5: If chip select stays high after a READ word, the next word follows with no dummy bit. The address wraps from the top of the array to 0.
- R6: When programming is enabled, WRITE stores its data word, MSB first, into the addressed word at the end of the programming cycle. No prior erase is needed.
- R7: ERASE sets every bit of the addressed word to 1. It leaves the other words unchanged.
- R8: Erase-all sets the whole array to ones. Write-all stores its single data word into every word of the array.
- R9: After the disable command, WRITE, ERASE, erase-all and write-all have no effect until the enable command is received again.
- R10: If chip select goes low and then high after a programming cycle has started, `dout` reads 0 while the cycle runs and 1 once it has finished. Frames that arrive while the device is busy are ignored.
- R11: `dout_oe` is low whenever the synchronized chip select is low.
- R12: If chip select goes low before the last bit of a frame, the partial frame is dropped, with no effect on the array.
- R13: Zero bits clocked in while chip select is high and before the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, asynchronous to clk |
| sk | input | 1 | Serial clock, asynchronous to clk |
| din | input | 1 | Serial data in, sampled on sk rising edges |
| org16 | input | 1 | Word-width strap: 1 selects 16-bit words, 0 selects 8-bit words |
| dout | output | 1 | Serial data out (read data or busy/ready status) |
| dout_oe | output | 1 | Output enable for dout; low means high impedance |

## Verification
An sk rising edge passes through two synchronizer flops and one edge-detect stage, and the output register then updates. `dout` therefore changes three system clocks after the pin edge. The bench holds each sk half-period for four clocks and samples `dout` at the end of the low half. At that point the value driven by the previous rising edge has settled, and the next edge has not yet arrived. Busy status is sampled four clocks after chip select rises. Ready is polled until it appears, with a bound well above `PROG_CYC`. Array contents are compared with a byte model in the bench, and each check is made only after the programming cycle has ended.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_HOLD} uw_state_e;
  typedef enum logic [1:0] {PG_WRITE, PG_ERASE, PG_ERAL, PG_WRAL} pg_kind_e;
  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;
  localparam logic [1:0] EX_DIS   = 2'b00;
  localparam logic [1:0] EX_WRAL  = 2'b01;
  localparam logic [1:0] EX_ERAL  = 2'b10;
  localparam logic [1:0] EX_EN    = 2'b11;
endpackage

// File: rtl/uwire_sync.sv
module uwire_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic din,
  output logic rst_n_s,
  output logic cs_s,
  output logic di_s,
  output logic sk_rise
);
  logic [1:0] rst_q, cs_q, sk_q, di_q;
  logic       sk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cs_q <= '0; sk_q <= '0; di_q <= '0; sk_prev_q <= 1'b0;
    end else begin
      cs_q      <= {cs_q[0], cs};
      sk_q      <= {sk_q[0], sk};
      di_q      <= {di_q[0], din};
      sk_prev_q <= sk_q[1];
    end
  end

  assign cs_s    = cs_q[1];
  assign di_s    = di_q[1];
  assign sk_rise = sk_q[1] & ~sk_prev_q;
endmodule

// File: rtl/uwire_array.sv
module uwire_array
  import uwire_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int PROG_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  pg_kind_e          kind,
  input  logic [ADDR_W:0]   addr,
  input  logic [15:0]       data,
  input  logic              org16,
  input  logic [ADDR_W:0]   rd_addr,
  input  logic              rd_org16,
  output logic              busy,
  output logic [15:0]       rd_word
);
  localparam int NB    = 2 << ADDR_W;
  localparam int TMR_W = $clog2(PROG_CYC + 1);

  logic [7:0]        mem [NB];
  pg_kind_e          p_kind_q;
  logic [ADDR_W:0]   p_addr_q;
  logic [15:0]       p_data_q;
  logic              p_org_q;
  logic [TMR_W-1:0]  tmr_q, tmr_n;
  logic              commit;

  always_comb begin
    tmr_n = tmr_q;
    if (req)               tmr_n = TMR_W'(PROG_CYC);
    else if (tmr_q != '0)  tmr_n = tmr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0; p_kind_q <= PG_WRITE; p_addr_q <= '0; p_data_q <= '0; p_org_q <= 1'b0;
    end else begin
      tmr_q <= tmr_n;
      if (req) begin
        p_kind_q <= kind; p_addr_q <= addr; p_data_q <= data; p_org_q <= org16;
      end
    end
  end

  assign busy   = (tmr_q != '0);
  assign commit = (tmr_q == TMR_W'(1));

  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam logic [ADDR_W:0] BI = (ADDR_W+1)'(i);
    logic       hit, en;
    logic [7:0] val;
    assign hit = (p_kind_q == PG_ERAL) || (p_kind_q == PG_WRAL) ||
                 (p_org_q ? (p_addr_q[ADDR_W-1:0] == BI[ADDR_W:1]) : (p_addr_q == BI));
    assign val = (p_kind_q == PG_ERASE || p_kind_q == PG_ERAL) ? 8'hFF :
                 (p_org_q && BI[0]) ? p_data_q[15:8] : p_data_q[7:0];
    assign en  = commit && hit;
    always_ff @(posedge clk) begin
      if (en) mem[i] <= val;
    end
  end

  assign rd_word = rd_org16 ? {mem[{rd_addr[ADDR_W-1:0], 1'b1}], mem[{rd_addr[ADDR_W-1:0], 1'b0}]}
                            : {mem[rd_addr], 8'h00};

  // R10
  req_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) req |-> !busy);
  // R6
  busy_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n) req |=> busy);
endmodule

// File: rtl/uwire_ctrl.sv
module uwire_ctrl
  import uwire_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sk_rise,
  input  logic              di_s,
  input  logic              org16,
  input  logic              busy,
  input  logic [15:0]       rd_word,
  output logic [ADDR_W:0]   rd_addr,
  output logic              pg_req,
  output pg_kind_e          pg_kind,
  output logic [ADDR_W:0]   pg_addr,
  output logic [15:0]       pg_data,
  output logic              do_q,
  output logic              oe_q
);
  localparam int AW8   = ADDR_W + 1;
  localparam int CNT_W = $clog2((AW8 > 16 ? AW8 : 16) + 1);

  uw_state_e        state_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_inc, addr_last, data_last, dw;
  logic [1:0]       op_q, op_n, ext;
  logic [AW8-1:0]   addr_q, addr_n, addr_nx;
  logic [15:0]      data_q, data_n, sh_q, sh_n;
  logic             wen_q, wen_n, armed_q, armed_n, do_n, oe_n;

  assign addr_nx   = {addr_q[AW8-2:0], di_s};
  assign ext       = org16 ? addr_nx[ADDR_W-1 -: 2] : addr_nx[AW8-1 -: 2];
  assign addr_last = org16 ? CNT_W'(ADDR_W - 1) : CNT_W'(ADDR_W);
  assign data_last = org16 ? CNT_W'(15) : CNT_W'(7);
  assign dw        = org16 ? CNT_W'(16) : CNT_W'(8);
  assign cnt_inc   = cnt_q + 1'b1;
  assign rd_addr   = (state_q == ST_READ) ? addr_q + 1'b1 : addr_nx;

  always_comb begin
    st_n = state_q; cnt_n = cnt_q; op_n = op_q; addr_n = addr_q; data_n = data_q;
    sh_n = sh_q; wen_n = wen_q; armed_n = armed_q; do_n = do_q; oe_n = oe_q;
    pg_req = 1'b0; pg_kind = PG_WRITE;
    if (!cs_s) begin
      st_n = ST_IDLE; oe_n = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          oe_n = armed_q; do_n = ~busy;
          if (sk_rise && di_s && !busy) begin
            st_n = ST_OPC; cnt_n = '0; armed_n = 1'b0; oe_n = 1'b0;
          end
        end
        ST_OPC: if (sk_rise) begin
          op_n = {op_q[0], di_s}; cnt_n = cnt_inc;
          if (cnt_q != '0) begin st_n = ST_ADDR; cnt_n = '0; end
        end
        ST_ADDR: if (sk_rise) begin
          addr_n = addr_nx; cnt_n = cnt_inc;
          if (cnt_q == addr_last) begin
            cnt_n = '0; st_n = ST_HOLD;
            case (op_q)
              OP_READ:  begin st_n = ST_READ; sh_n = rd_word; do_n = 1'b0; oe_n = 1'b1; end
              OP_WRITE: st_n = ST_DATA;
              OP_ERASE: begin pg_req = wen_q; pg_kind = PG_ERASE; end
              default: begin
                case (ext)
                  EX_EN:   wen_n = 1'b1;
                  EX_DIS:  wen_n = 1'b0;
                  EX_ERAL: begin pg_req = wen_q; pg_kind = PG_ERAL; end
                  default: st_n = ST_DATA;
                endcase
              end
            endcase
          end
        end
        ST_DATA: if (sk_rise) begin
          data_n = {data_q[14:0], di_s}; cnt_n = cnt_inc;
          if (cnt_q == data_last) begin
            st_n = ST_HOLD; pg_req = wen_q;
            pg_kind = (op_q == OP_WRITE) ? PG_WRITE : PG_WRAL;
          end
        end
        ST_READ: if (sk_rise) begin
          if (cnt_q == dw) begin
            addr_n = addr_q + 1'b1; do_n = rd_word[15];
            sh_n = {rd_word[14:0], 1'b0}; cnt_n = CNT_W'(1);
          end else begin
            do_n = sh_q[15]; sh_n = {sh_q[14:0], 1'b0}; cnt_n = cnt_inc;
          end
        end
        default: ;
      endcase
    end
    if (pg_req) armed_n = 1'b1;
  end

  assign pg_addr = addr_n;
  assign pg_data = data_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cnt_q <= '0; op_q <= '0; addr_q <= '0; data_q <= '0; sh_q <= '0;
      wen_q <= 1'b0; armed_q <= 1'b0; do_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      state_q <= st_n; cnt_q <= cnt_n; op_q <= op_n; addr_q <= addr_n; data_q <= data_n;
      sh_q <= sh_n; wen_q <= wen_n; armed_q <= armed_n; do_q <= do_n; oe_q <= oe_n;
    end
  end

  // R9
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n) pg_req |-> wen_q);
  // R4
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && $past(state_q) != ST_READ) |-> (!do_q && oe_q));
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
  import uwire_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int PROG_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic din,
  input  logic org16,
  output logic dout,
  output logic dout_oe
);
  logic            rst_n_s, cs_s, di_s, sk_rise, busy, pg_req;
  pg_kind_e        pg_kind;
  logic [ADDR_W:0] rd_addr, pg_addr;
  logic [15:0]     rd_word, pg_data;

  uwire_sync u_sync (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .din(din),
    .rst_n_s(rst_n_s), .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise)
  );

  uwire_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .cs_s(cs_s), .sk_rise(sk_rise), .di_s(di_s),
    .org16(org16), .busy(busy), .rd_word(rd_word), .rd_addr(rd_addr),
    .pg_req(pg_req), .pg_kind(pg_kind), .pg_addr(pg_addr), .pg_data(pg_data),
    .do_q(dout), .oe_q(dout_oe)
  );

  uwire_array #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC)) u_array (
    .clk(clk), .rst_n(rst_n_s), .req(pg_req), .kind(pg_kind), .addr(pg_addr),
    .data(pg_data), .org16(org16), .rd_addr(rd_addr), .rd_org16(org16),
    .busy(busy), .rd_word(rd_word)
  );

  // R11
  hiz_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cs_s |=> !dout_oe);
endmodule

// File: tb/uwire_eeprom_tb.sv
module uwire_eeprom_tb;
  localparam int AW = 6;
  localparam int PC = 300;
  localparam int H  = 4;
  localparam int NB = 2 << AW;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, din = 1'b0, org16 = 1'b1;
  logic dout, dout_oe;
  int   n_chk = 0, n_fail = 0;
  logic [7:0] mref [NB];

  uwire_eeprom #(.ADDR_W(AW), .PROG_CYC(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .din(din), .org16(org16),
    .dout(dout), .dout_oe(dout_oe)
  );

  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic b, output logic s);
    din = b; tick(H); s = dout; sk = 1'b1; tick(H); sk = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic s;
    for (int i = n - 1; i >= 0; i--) bitx(v[i], s);
  endtask

  task automatic cs_hi();
    cs = 1'b1; tick(4);
  endtask

  task automatic cs_lo();
    cs = 1'b0; din = 1'b0; tick(4);
    chk(dout_oe == 1'b0, "R11 oe after cs low", {15'd0, dout_oe}, 16'd0);
  endtask

  function automatic int abits();
    return org16 ? AW : AW + 1;
  endfunction

  task automatic frame(input logic [1:0] op, input int addr);
    send(32'd1, 1); send({30'd0, op}, 2); send(addr, abits());
  endtask

  task automatic cmd_ext(input logic [1:0] code);
    cs_hi(); frame(2'b00, int'(code) << (abits() - 2)); cs_lo();
  endtask

  task automatic wait_ready(input logic expect_busy, input string req);
    int k = 0;
    cs_hi();
    if (expect_busy) chk(dout_oe && dout == 1'b0, req, {14'd0, dout_oe, dout}, 16'h2);
    while (dout !== 1'b1 && k < 4 * PC) begin tick(1); k++; end
    chk(dout_oe && dout == 1'b1, req, {14'd0, dout_oe, dout}, 16'h3);
    cs_lo();
  endtask

  function automatic logic [15:0] model_word(input int a);
    if (org16) return {mref[2 * (a % (NB / 2)) + 1], mref[2 * (a % (NB / 2))]};
    return {8'h00, mref[a % NB]};
  endfunction

  task automatic model_put(input int a, input logic [15:0] d);
    if (org16) begin mref[2 * a] = d[7:0]; mref[2 * a + 1] = d[15:8]; end
    else mref[a] = d[7:0];
  endtask

  task automatic rd_check(input int addr, input int nw, input int lead, input string req);
    logic s;
    logic [15:0] w;
    int dw = org16 ? 16 : 8;
    cs_hi();
    send(32'd0, lead);
    frame(2'b10, addr);
    bitx(1'b0, s);
    chk(s == 1'b0 && dout_oe, "R4 dummy zero", {15'd0, s}, 16'd0);
    for (int i = 0; i < nw; i++) begin
      w = '0;
      for (int b = 0; b < dw; b++) begin bitx(1'b0, s); w = {w[14:0], s}; end
      chk(w == model_word(addr + i), req, w, model_word(addr + i));
    end
    cs_lo();
  endtask

  task automatic do_write(input int a, input logic [15:0] d);
    cs_hi(); frame(2'b01, a); send({16'd0, d}, org16 ? 16 : 8); cs_lo();
  endtask

  initial begin
    tick(190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    chk(dout_oe == 1'b0, "R1 reset oe", {15'd0, dout_oe}, 16'd0);
    // R1: write before enable starts no cycle, so no status after cs toggle
    do_write(5, 16'h1234);
    cs_hi(); tick(8);
    chk(dout_oe == 1'b0, "R1 no cycle while disabled", {15'd0, dout_oe}, 16'd0);
    cs_lo();

    // R2 enable, then erase-all (R8)
    cmd_ext(2'b11);
    cmd_ext(2'b10);
    wait_ready(1'b1, "R10 status after erase-all");
    for (int i = 0; i < NB; i++) mref[i] = 8'hFF;
    rd_check(0, 64, 0, "R8 erase-all x16");

    // R6 write sweep, sequential read with wrap (R5)
    for (int a = 0; a < 64; a++) begin
      logic [15:0] p = 16'((a * 16'h9E37) ^ 16'h5A5A);
      do_write(a, p); model_put(a, p);
      wait_ready(1'b1, "R10 busy then ready");
    end
    rd_check(0, 65, 0, "R6 R5 write sweep readback");
    rd_check(62, 4, 0, "R5 wrap x16");

    // R10 frame while busy is ignored
    do_write(3, 16'h1111); model_put(3, 16'h1111);
    do_write(4, 16'h2222);
    wait_ready(1'b0, "R10 ready after ignored frame");
    rd_check(3, 2, 0, "R10 busy frame ignored");

    // R7 erase one word, neighbours intact (R2 opcode 11)
    cs_hi(); frame(2'b11, 7); cs_lo();
    wait_ready(1'b1, "R7 erase status");
    model_put(7, 16'hFFFF);
    rd_check(6, 3, 0, "R7 R2 erase word");

    // R3 byte mode mapping
    org16 = 1'b0;
    rd_check(20, 4, 0, "R3 x8 bytes of words");
    do_write(33, 16'h005E); model_put(33, 16'h005E);
    wait_ready(1'b1, "R3 x8 write status");
    rd_check(NB - 2, 4, 0, "R5 wrap x8");
    cs_hi(); frame(2'b11, 9); cs_lo();
    wait_ready(1'b1, "R7 x8 erase status");
    model_put(9, 16'h00FF);
    org16 = 1'b1;
    rd_check(16, 1, 0, "R3 high byte from x8 write");
    rd_check(4, 1, 0, "R7 x8 erase one byte");

    // R13 leading zeros before the start bit
    rd_check(12, 2, 3, "R13 leading zeros");

    // R12 abort mid data
    cs_hi(); frame(2'b01, 8); send(32'hAB, 8); cs_lo();
    cs_hi(); tick(8);
    chk(dout_oe == 1'b0, "R12 no cycle after abort", {15'd0, dout_oe}, 16'd0);
    cs_lo();
    rd_check(8, 1, 0, "R12 aborted frame no effect");

    // R8 write-all x16 then x8
    cs_hi(); frame(2'b00, 1 << (abits() - 2)); send(32'hA5C3, 16); cs_lo();
    wait_ready(1'b1, "R8 write-all status");
    for (int a = 0; a < 64; a++) model_put(a, 16'hA5C3);
    rd_check(0, 64, 0, "R8 write-all x16");
    org16 = 1'b0;
    cs_hi(); frame(2'b00, 1 << (abits() - 2)); send(32'h3C, 8); cs_lo();
    wait_ready(1'b1, "R8 write-all x8 status");
    for (int i = 0; i < NB; i++) mref[i] = 8'h3C;
    org16 = 1'b1;
    rd_check(0, 64, 0, "R8 write-all x8");

    // R9 disable blocks programming; reads still work (R4)
    cmd_ext(2'b00);
    do_write(5, 16'h7777);
    cs_hi(); tick(8);
    chk(dout_oe == 1'b0, "R9 no cycle after disable", {15'd0, dout_oe}, 16'd0);
    cs_lo();
    cmd_ext(2'b10);
    cs_hi(); frame(2'b11, 6); cs_lo();
    rd_check(4, 4, 0, "R9 disabled programming ignored");
    cmd_ext(2'b11);
    do_write(5, 16'h7777); model_put(5, 16'h7777);
    wait_ready(1'b1, "R9 re-enable status");
    rd_check(5, 1, 0, "R9 re-enabled write");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule